// File: doc/BRIEF.md
# Jump Resolution Unit

This block settles the outcome of a jump-class instruction for a 64-bit virtual-machine style core. Each cycle that `issue_valid` is high it takes the decoded jump code, a width select, a source select, the two register operands, the 32-bit immediate, the 16-bit signed slot offset and the byte-address program counter of the jump. One cycle later it presents whether the jump is taken, the next program counter, and one-cycle strobes for the call and exit codes.

Comparisons cover equality, unsigned ordering, signed ordering and a bit-test, each in a full 64-bit form and a narrow form that looks only at the low 32 bits. Branch offsets count 8-byte instruction slots measured from the slot that follows the jump. Carrying out a call or an exit, holding registers and fetching instructions belong to neighbouring blocks.

Top module: `jump_resolve_unit`

## Requirements
- R1: Code 0 (unconditional) is always taken, whatever the operand values.
- R2: Code 1 is taken when the two operands are equal; code 5 is taken when they differ.
- R3: Codes 2 (greater), 3 (greater or equal), 10 (less) and 11 (less or equal) order the operands as unsigned numbers, destination on the left.
- R4: Codes 6 (greater), 7 (greater or equal), 12 (less) and 13 (less or equal) order the operands as two's-complement signed numbers, destination on the left.
- R5: Code 4 is taken when the bitwise AND of the two operands is nonzero.
- R6: With `cmp_narrow` high, every comparison uses only bits 31:0 of both operands (signed forms use bit 31 as sign); bits 63:32 have no effect on the outcome.
- R7: Code 8 raises `call_strobe` and code 9 raises `exit_strobe` for exactly one cycle; neither is taken and `next_pc` equals the jump's own program counter. At most one of `br_taken`, `call_strobe`, `exit_strobe` is high.
- R8: A taken jump sets `next_pc` to PC + (offset + 1) × 8, with the offset sign-extended and the sum wrapping at 64 bits.
- R9: A jump that is not taken, including the unassigned codes 14 and 15 (never taken), sets `next_pc` to PC + 8.
- R10: With `use_reg` low the second operand is the immediate sign-extended to 64 bits; with it high the second operand is `src_val`.
- R11: Results appear on the clock edge after the issue; in a cycle with no result, `res_valid`, `br_taken`, `call_strobe` and `exit_strobe` are low.
- R12: Synchronous reset clears `res_valid`, `br_taken`, `call_strobe`, `exit_strobe` and `next_pc` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A jump is presented this cycle |
| jump_code | input | 4 | Jump operation code |
| cmp_narrow | input | 1 | 1: compare low 32 bits; 0: compare 64 bits |
| use_reg | input | 1 | 1: second operand is `src_val`; 0: immediate |
| dst_val | input | 64 | Destination register value (left operand) |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Signed immediate |
| branch_off | input | 16 | Signed offset in instruction slots |
| cur_pc | input | 64 | Byte address of the jump |
| res_valid | output | 1 | Result registers hold a fresh result |
| br_taken | output | 1 | The jump is taken |
| next_pc | output | 64 | Next program counter |
| call_strobe | output | 1 | One-cycle call indication |
| exit_strobe | output | 1 | One-cycle exit indication |

## Verification
Every result passes through exactly one register, so taken, next program counter and both strobes are due on the first rising edge after the issue cycle. The bench drives an issue on a falling edge, drops `issue_valid` on the next falling edge and compares outputs there, half a cycle after the result edge; a further falling edge with no issue confirms the strobes and taken flag fall back after one cycle. The sweep walks every code, both widths and both operand sources across operand pairs chosen to split signed from unsigned order and upper from lower halves.

// File: rtl/jru_pkg.sv
package jru_pkg;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_EQ     = 4'h1,
        JC_UGT    = 4'h2,
        JC_UGE    = 4'h3,
        JC_BITANY = 4'h4,
        JC_NE     = 4'h5,
        JC_SGT    = 4'h6,
        JC_SGE    = 4'h7,
        JC_CALL   = 4'h8,
        JC_EXIT   = 4'h9,
        JC_ULT    = 4'hA,
        JC_ULE    = 4'hB,
        JC_SLT    = 4'hC,
        JC_SLE    = 4'hD
    } jump_code_t;

    // Raw relations between the left (destination) and right operand.
    typedef struct packed {
        logic eq;
        logic ult;
        logic slt;
        logic any;
    } cmp_flags_t;

    // Outcome of one jump before it is registered.
    typedef struct packed {
        logic taken;
        logic call;
        logic exit;
    } jump_kind_t;

    function automatic logic cond_true(input logic [3:0] code, input cmp_flags_t f);
        logic r;
        case (jump_code_t'(code))
            JC_ALWAYS: r = 1'b1;
            JC_EQ:     r = f.eq;
            JC_NE:     r = !f.eq;
            JC_UGT:    r = !f.ult && !f.eq;
            JC_UGE:    r = !f.ult;
            JC_ULT:    r = f.ult;
            JC_ULE:    r = f.ult || f.eq;
            JC_SGT:    r = !f.slt && !f.eq;
            JC_SGE:    r = !f.slt;
            JC_SLT:    r = f.slt;
            JC_SLE:    r = f.slt || f.eq;
            JC_BITANY: r = f.any;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jru_operand_sel.sv
module jru_operand_sel #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              use_reg,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        opa     = dst_val;
        opb     = use_reg ? src_val : imm_ext;
    end
endmodule

// File: rtl/jru_lane_cmp.sv
module jru_lane_cmp
    import jru_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output cmp_flags_t   flags
);
    always_comb begin
        flags.eq  = (a == b);
        flags.ult = (a < b);
        flags.slt = ($signed(a) < $signed(b));
        flags.any = |(a & b);
    end
endmodule

// File: rtl/jru_target.sv
module jru_target
    import jru_pkg::*;
#(
    parameter int PC_W       = 64,
    parameter int OFF_W      = 16,
    parameter int SLOT_BYTES = 8
) (
    input  logic [3:0]      code,
    input  cmp_flags_t      flags,
    input  logic [PC_W-1:0] pc,
    input  logic [OFF_W-1:0] off,
    output jump_kind_t      kind,
    output logic [PC_W-1:0] nxt
);
    localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);
    localparam int OEXT_W     = PC_W - OFF_W;

    logic [PC_W-1:0] slots;
    logic [PC_W-1:0] jump_pc;
    logic [PC_W-1:0] fall_pc;

    always_comb begin
        slots      = {{OEXT_W{off[OFF_W-1]}}, off} + PC_W'(1);
        jump_pc    = pc + (slots << SLOT_SHIFT);
        fall_pc    = pc + PC_W'(SLOT_BYTES);
        kind.call  = (code == 4'(JC_CALL));
        kind.exit  = (code == 4'(JC_EXIT));
        kind.taken = cond_true(code, flags);
        if (kind.call || kind.exit) nxt = pc;
        else if (kind.taken)        nxt = jump_pc;
        else                        nxt = fall_pc;
    end
endmodule

// File: rtl/jump_resolve_unit.sv
module jump_resolve_unit
    import jru_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int IMM_W      = 32,
    parameter int OFF_W      = 16,
    parameter int PC_W       = 64,
    parameter int SLOT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [3:0]        jump_code,
    input  logic              cmp_narrow,
    input  logic              use_reg,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [OFF_W-1:0]  branch_off,
    input  logic [PC_W-1:0]   cur_pc,
    output logic              res_valid,
    output logic              br_taken,
    output logic [PC_W-1:0]   next_pc,
    output logic              call_strobe,
    output logic              exit_strobe
);
    localparam int LANES = 2;   // lane 0: full width, lane 1: half width

    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    cmp_flags_t        lane_flags [LANES];
    cmp_flags_t        use_flags;
    jump_kind_t        kind_c;
    logic [PC_W-1:0]   nxt_c;

    jru_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .use_reg (use_reg),
        .dst_val (dst_val),
        .src_val (src_val),
        .imm_val (imm_val),
        .opa     (opa),
        .opb     (opb)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = DATA_W >> g;
        jru_lane_cmp #(.W(LW)) u_cmp (
            .a     (opa[LW-1:0]),
            .b     (opb[LW-1:0]),
            .flags (lane_flags[g])
        );
    end

    always_comb use_flags = cmp_narrow ? lane_flags[1] : lane_flags[0];

    jru_target #(.PC_W(PC_W), .OFF_W(OFF_W), .SLOT_BYTES(SLOT_BYTES)) u_tgt (
        .code  (jump_code),
        .flags (use_flags),
        .pc    (cur_pc),
        .off   (branch_off),
        .kind  (kind_c),
        .nxt   (nxt_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            br_taken    <= 1'b0;
            call_strobe <= 1'b0;
            exit_strobe <= 1'b0;
            next_pc     <= '0;
        end else begin
            res_valid   <= issue_valid;
            br_taken    <= issue_valid && kind_c.taken;
            call_strobe <= issue_valid && kind_c.call;
            exit_strobe <= issue_valid && kind_c.exit;
            if (issue_valid) next_pc <= nxt_c;
        end
    end

    // R7: outcomes are mutually exclusive
    assert_outcome_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({br_taken, call_strobe, exit_strobe}));

    // R11: nothing is signalled without a fresh result
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!br_taken && !call_strobe && !exit_strobe));

    // R11: a result follows an issue by one cycle
    assert_result_latency_R11: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> res_valid);

    // R7: call strobe only for a call code issued one cycle earlier
    assert_call_source_R7: assert property (@(posedge clk) disable iff (rst)
        call_strobe |-> ($past(issue_valid) && $past(jump_code) == 4'(JC_CALL)));

    // R7: call and exit leave the program counter at the jump itself
    assert_strobe_pc_R7: assert property (@(posedge clk) disable iff (rst)
        (call_strobe || exit_strobe) |-> next_pc == $past(cur_pc));

    // R1: unconditional code always taken
    assert_always_taken_R1: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(jump_code) == 4'(JC_ALWAYS)) |-> br_taken);

    // R9: fall-through steps one slot
    assert_fallthrough_R9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !br_taken && !call_strobe && !exit_strobe)
            |-> next_pc == $past(cur_pc) + PC_W'(SLOT_BYTES));
endmodule

// File: tb/tb_jump_resolve_unit.sv
`timescale 1ns/1ps
module tb_jump_resolve_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [3:0]  jump_code = '0;
    logic        cmp_narrow = 1'b0;
    logic        use_reg = 1'b0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm_val = '0;
    logic [15:0] branch_off = '0;
    logic [63:0] cur_pc = '0;
    logic        res_valid, br_taken, call_strobe, exit_strobe;
    logic [63:0] next_pc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    jump_resolve_unit dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .jump_code(jump_code),
        .cmp_narrow(cmp_narrow), .use_reg(use_reg), .dst_val(dst_val),
        .src_val(src_val), .imm_val(imm_val), .branch_off(branch_off),
        .cur_pc(cur_pc), .res_valid(res_valid), .br_taken(br_taken),
        .next_pc(next_pc), .call_strobe(call_strobe), .exit_strobe(exit_strobe)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int code);
        case (code)
            0:             return "R1";
            1, 5:          return "R2";
            2, 3, 10, 11:  return "R3";
            6, 7, 12, 13:  return "R4";
            4:             return "R5";
            8, 9:          return "R7";
            default:       return "R9";
        endcase
    endfunction

    function automatic bit model_take(input int code, input logic [63:0] a,
                                      input logic [63:0] b, input bit nar);
        logic [63:0] ua, ub, sa, sb;
        bit eq, lu, ls, an;
        ua = nar ? {32'h0, a[31:0]} : a;
        ub = nar ? {32'h0, b[31:0]} : b;
        sa = nar ? {{32{a[31]}}, a[31:0]} : a;
        sb = nar ? {{32{b[31]}}, b[31:0]} : b;
        eq = (ua == ub);
        lu = (ua < ub);
        ls = ($signed(sa) < $signed(sb));
        an = ((ua & ub) != 0);
        case (code)
            0: return 1;  1: return eq;  5: return !eq;
            2: return ub < ua;  3: return !lu;  10: return lu;  11: return lu || eq;
            6: return $signed(sb) < $signed(sa);  7: return !ls;  12: return ls;  13: return ls || eq;
            4: return an;
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] model_target(input logic [63:0] pc, input logic [15:0] off);
        longint s;
        s = longint'($signed(off));
        return pc + 64'((s + 1) * 8);
    endfunction

    task automatic pattern(input int p, output logic [63:0] d, output logic [63:0] s,
                           output logic [31:0] im);
        case (p)
            0: begin d = 64'd5; s = 64'd5; im = 32'd5; end
            1: begin d = 64'd3; s = 64'd7; im = 32'd7; end
            2: begin d = '1; s = 64'd1; im = 32'd1; end
            3: begin d = 64'h8000_0000_0000_0000; s = 64'h7FFF_FFFF_FFFF_FFFF; im = 32'h7FFF_FFFF; end
            4: begin d = 64'h1_0000_0005; s = 64'd5; im = 32'd5; end
            5: begin d = 64'hF0; s = 64'h0F; im = 32'h0F; end
            6: begin d = 64'hFF; s = 64'h81; im = 32'h8000_0001; end
            7: begin d = 64'h8000_0000; s = 64'd1; im = 32'd1; end
            8: begin d = '1; s = '1; im = 32'hFFFF_FFFF; end
            default: begin d = 64'h1234_5678_9ABC_DEF0; s = 64'h1234_5678_0000_0000; im = 32'h9ABC_DEF0; end
        endcase
    endtask

    // Issue on a falling edge, result is registered on the next rising edge,
    // sampled on the following falling edge.
    task automatic issue(input int code, input bit nar, input bit ur, input logic [63:0] d,
                         input logic [63:0] s, input logic [31:0] im,
                         input logic [15:0] off, input logic [63:0] pc);
        @(negedge clk);
        issue_valid = 1'b1; jump_code = 4'(code); cmp_narrow = nar; use_reg = ur;
        dst_val = d; src_val = s; imm_val = im; branch_off = off; cur_pc = pc;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic expect_result(input string tag, input int code, input bit nar, input bit ur,
                                 input logic [63:0] d, input logic [63:0] s,
                                 input logic [31:0] im, input logic [15:0] off,
                                 input logic [63:0] pc);
        logic [63:0] b, epc;
        bit tk, cl, ex;
        b  = ur ? s : {{32{im[31]}}, im};
        tk = model_take(code, d, b, nar);
        cl = (code == 8);
        ex = (code == 9);
        epc = (cl || ex) ? pc : (tk ? model_target(pc, off) : pc + 64'd8);
        chk({tag, " flags"}, {60'h0, res_valid, br_taken, call_strobe, exit_strobe},
            {60'h0, 1'b1, tk, cl, ex});
        chk((cl || ex) ? {tag, " pc"} : (tk ? "R8 pc" : "R9 pc"), next_pc, epc);
    endtask

    initial begin
        logic [63:0] d, s;
        logic [31:0] im;
        logic [15:0] off;
        logic [63:0] pc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12 reset", {59'h0, res_valid, br_taken, call_strobe, exit_strobe, 1'b0}, 64'h0);
        chk("R12 reset pc", next_pc, 64'h0);
        rst = 1'b0;

        // Sweep: every code, both widths, both sources, all operand patterns
        for (int code = 0; code < 16; code++) begin
            for (int nar = 0; nar < 2; nar++) begin
                for (int ur = 0; ur < 2; ur++) begin
                    for (int p = 0; p < 10; p++) begin
                        pattern(p, d, s, im);
                        off = 16'(p * 37 - 100);
                        pc  = (p == 9) ? 64'hFFFF_FFFF_FFFF_FFF8 : 64'h4000 + 64'(code * 256 + p * 8);
                        issue(code, nar[0], ur[0], d, s, im, off, pc);
                        expect_result(tag_of(code), code, nar[0], ur[0], d, s, im, off, pc);
                    end
                end
            end
        end

        // R6: narrow equality ignores differing upper halves
        issue(1, 1'b1, 1'b1, 64'hDEAD_0000_0000_0042, 64'h0000_BEEF_0000_0042, 32'h0, 16'd4, 64'h100);
        chk("R6 narrow eq taken", {63'h0, br_taken}, 64'h1);
        chk("R6 narrow eq pc", next_pc, 64'h100 + 64'd40);
        // R6: narrow signed uses bit 31 as sign (0x8000_0000 < 1)
        issue(12, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'd1, 32'h0, 16'd0, 64'h200);
        chk("R6 narrow signed less", {63'h0, br_taken}, 64'h1);

        // R10: immediate sign-extended, register ignored when use_reg low
        issue(1, 1'b0, 1'b0, '1, 64'd0, 32'hFFFF_FFFF, 16'd1, 64'h300);
        chk("R10 imm sign-extended eq", {63'h0, br_taken}, 64'h1);
        issue(1, 1'b0, 1'b0, 64'd9, 64'd9, 32'd8, 16'd1, 64'h300);
        chk("R10 src ignored with imm select", {63'h0, br_taken}, 64'h0);

        // R8: offset -1 lands on the jump itself, -2 one slot back
        issue(0, 1'b0, 1'b0, 64'd0, 64'd0, 32'd0, 16'hFFFF, 64'h800);
        chk("R8 offset -1", next_pc, 64'h800);
        issue(0, 1'b0, 1'b0, 64'd0, 64'd0, 32'd0, 16'hFFFE, 64'h800);
        chk("R8 offset -2", next_pc, 64'h7F8);
        issue(0, 1'b0, 1'b0, 64'd0, 64'd0, 32'd0, 16'h7FFF, 64'h0);
        chk("R8 offset max", next_pc, 64'h4_0000);

        // R7 / R11: call strobe lasts one cycle, then everything falls quiet
        issue(8, 1'b0, 1'b0, 64'd0, 64'd0, 32'd0, 16'd0, 64'h900);
        chk("R7 call strobe", {63'h0, call_strobe}, 64'h1);
        @(negedge clk);
        chk("R7 call strobe one cycle", {63'h0, call_strobe}, 64'h0);
        chk("R11 idle quiet", {61'h0, res_valid, br_taken, exit_strobe}, 64'h0);
        chk("R11 pc held when idle", next_pc, 64'h900);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule